// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the slave side of a serial NOR flash that looks after the status register. It watches a serial stream framed by chip select and runs in SPI mode 0. It sees SCLK, chip select and MOSI as ordinary inputs and samples them with the system clock. It decodes four one-byte instructions: set the write-enable latch, clear it, read status and write status. It keeps the busy flag, the write-enable latch, two block-protect bits and a status-write lock bit, and it shifts the status byte out on MISO.

An external program/erase engine asks for permission through two outputs. The first permits a program or sector/block erase at the address on `reqAddr`. The second permits a chip erase. The engine reports its activity back on `engBusy`. A down-counter stands in for the time a status write takes.

Top module: `sflash_status_ctrl`

## Requirements
- R1: The status byte has busy in bit 0, the write-enable latch in bit 1, protect bit P0 in bit 2, protect bit P1 in bit 3 and the lock bit in bit 7. Bits 4 to 6 always read 0.
- R2: A frame that starts with opcode 0x05 returns the status byte MSB first. Bits change on falling SCLK edges and the master samples them on rising edges. The byte repeats for as long as chip select stays low.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R4: An instruction takes effect only when chip select rises on a byte boundary. The frame must hold exactly one byte for 0x06 or 0x04, and exactly two bytes (opcode then data) for 0x01. Any other frame is ignored.
- R5: Opcode 0x01 is accepted only while the write-enable latch is 1. It loads the lock bit from data bit 7, P1 from data bit 3 and P0 from data bit 2. Nothing else changes the lock bit or P1:P0.
- R6: An accepted status write holds busy at 1 for WRSR_CYCLES clock cycles, then clears busy and the write-enable latch. Status reads work while busy is 1.
- R7: When the lock bit is 1 and `wpN` is low, a status write is rejected. The lock bit, P1:P0 and the write-enable latch keep their values.
- R8: Busy reads 1 while `engBusy` is high. The write-enable latch clears when `engBusy` falls.
- R9: While busy is 1, opcodes 0x06, 0x04 and 0x01 are ignored.
- R10: `permitArea` is 1 only when the write-enable latch is 1, busy is 0 and `reqAddr` lies outside the protected area. For P1:P0 the protected area is 00 none, 01 upper quarter, 10 upper half, 11 the whole array.
- R11: `permitChip` is 1 only when the write-enable latch is 1, busy is 0 and P1:P0 is 00.
- R12: After reset the status byte is 0x00, MISO is 0 and both permits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock (mode 0) |
| mosi | input | 1 | Serial data in |
| wpN | input | 1 | Write-protect pin, active low |
| engBusy | input | 1 | Program/erase engine busy |
| reqAddr | input | ADDR_W | Target address of the pending array operation |
| miso | output | 1 | Serial data out |
| permitArea | output | 1 | Program/sector/block erase allowed at reqAddr |
| permitChip | output | 1 | Chip erase allowed |

## Verification
The assertions check on every cycle that the lock and protect bits change only on an accepted status write and never while hardware protection is active. They also check that a status write strobe needs the latch set with busy clear, that busy follows at once, and that the latch can never be set while busy. They check that the latch falls after the engine finishes. The bench scenarios are needed for the serial framing: byte alignment, wrong byte counts, MSB-first output and the repeated status byte. Scenarios also cover the sweep of every protect setting against area boundary addresses, and what a status read shows during a status write.

// File: rtl/sflash_status_pkg.sv
package sflash_status_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic wrStatus;
    logic txEn;
  } srStrobe_t;
endpackage

// File: rtl/sflash_status_dp.sv
module sflash_status_dp
  import sflash_status_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int WRSR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              wpN,
  input  logic              engBusy,
  input  logic [ADDR_W-1:0] reqAddr,
  input  srStrobe_t         str,
  output logic              byteDone,
  output logic [7:0]        rxByte,
  output logic              frameEnd,
  output logic              aligned,
  output logic [1:0]        byteCnt,
  output logic              wel,
  output logic              wip,
  output logic              hwProt,
  output logic              miso,
  output logic              permitArea,
  output logic              permitChip
);
  localparam int TW = $clog2(WRSR_CYCLES + 1);
  localparam logic [TW-1:0] TLOAD = TW'(WRSR_CYCLES);
  localparam logic [ADDR_W-1:0] QTR3 = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] HALF = {1'b1, {(ADDR_W-1){1'b0}}};

  logic csQ, csPrev, sclkQ, sclkPrev, mosiQ, engPrev;
  logic [2:0] bitCnt;
  logic [6:0] rxPart;
  logic newSrwd;
  logic [1:0] newBp;
  logic srwd;
  logic [1:0] bp;
  logic [TW-1:0] timer;
  logic [7:0] status, txHold;
  logic sclkRise, sclkFall, csFall, engDone, tmrDone, inProt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ <= 1'b1; csPrev <= 1'b1; sclkQ <= 1'b0; sclkPrev <= 1'b0;
      mosiQ <= 1'b0; engPrev <= 1'b0;
    end else begin
      csQ <= csN; csPrev <= csQ; sclkQ <= sclk; sclkPrev <= sclkQ;
      mosiQ <= mosi; engPrev <= engBusy;
    end
  end

  assign sclkRise = sclkQ & ~sclkPrev & ~csQ;
  assign sclkFall = ~sclkQ & sclkPrev & ~csQ;
  assign csFall   = ~csQ & csPrev;
  assign frameEnd = csQ & ~csPrev;
  assign aligned  = (bitCnt == 3'd0);
  assign byteDone = sclkRise & (bitCnt == 3'd7);
  assign rxByte   = {rxPart, mosiQ};

  // bit and byte counting within one chip-select frame
  always_ff @(posedge clk) begin
    if (!rstN || csFall) begin
      bitCnt <= '0; byteCnt <= '0; rxPart <= '0;
    end else if (sclkRise) begin
      rxPart <= {rxPart[5:0], mosiQ};
      bitCnt <= bitCnt + 3'd1;
      if (bitCnt == 3'd7 && byteCnt != 2'd3) byteCnt <= byteCnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newSrwd <= 1'b0; newBp <= '0;
    end else if (byteDone) begin
      newSrwd <= rxByte[7]; newBp <= rxByte[3:2];
    end
  end

  assign engDone = engPrev & ~engBusy;
  assign tmrDone = (timer == TW'(1));
  assign wip     = (timer != '0) | engBusy;
  assign hwProt  = srwd & ~wpN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel <= 1'b0; srwd <= 1'b0; bp <= '0; timer <= '0;
    end else begin
      if (engDone || tmrDone || str.clrWel) wel <= 1'b0;
      else if (str.setWel) wel <= 1'b1;
      if (str.wrStatus) begin
        srwd <= newSrwd; bp <= newBp; timer <= TLOAD;
      end else if (timer != '0) begin
        timer <= timer - TW'(1);
      end
    end
  end

  assign status = {srwd, 3'b000, bp, wel, wip};

  // serial output: snapshot at each byte start, one bit per falling edge
  always_ff @(posedge clk) begin
    if (!rstN || csQ) begin
      miso <= 1'b0; txHold <= '0;
    end else if (sclkFall && str.txEn) begin
      if (aligned) begin
        miso <= status[7]; txHold <= status;
      end else begin
        miso <= txHold[~bitCnt];
      end
    end
  end

  always_comb begin
    case (bp)
      2'b00:   inProt = 1'b0;
      2'b01:   inProt = (reqAddr >= QTR3);
      2'b10:   inProt = (reqAddr >= HALF);
      default: inProt = 1'b1;
    endcase
  end

  assign permitArea = wel & ~wip & ~inProt;
  assign permitChip = wel & ~wip & (bp == 2'b00);

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !str.wrStatus |=> $stable({srwd, bp})); // R5
  AST_WRSR_GATE: assert property (@(posedge clk) disable iff (!rstN)
    str.wrStatus |-> (wel && !wip)); // R5
  AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (srwd && !wpN) |=> $stable({srwd, bp})); // R7
  AST_WIP_START: assert property (@(posedge clk) disable iff (!rstN)
    str.wrStatus |=> wip); // R6
  AST_ENG_CLR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(engBusy) |=> !wel); // R8
  AST_BUSY_NOSET: assert property (@(posedge clk) disable iff (!rstN)
    (wip && !wel) |=> !wel); // R9
endmodule

// File: rtl/sflash_status_ctl.sv
module sflash_status_ctl
  import sflash_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteDone,
  input  logic [7:0] rxByte,
  input  logic       frameEnd,
  input  logic       aligned,
  input  logic [1:0] byteCnt,
  input  logic       wel,
  input  logic       wip,
  input  logic       hwProt,
  output srStrobe_t  str
);
  logic [7:0] opcode;
  logic oneByte, twoByte;

  always_ff @(posedge clk) begin
    if (!rstN) opcode <= '0;
    else if (byteDone && byteCnt == 2'd0) opcode <= rxByte;
  end

  assign oneByte = frameEnd & aligned & (byteCnt == 2'd1);
  assign twoByte = frameEnd & aligned & (byteCnt == 2'd2);

  always_comb begin
    str.setWel   = oneByte & (opcode == OP_WREN) & ~wip;
    str.clrWel   = oneByte & (opcode == OP_WRDI) & ~wip;
    str.wrStatus = twoByte & (opcode == OP_WRSR) & wel & ~wip & ~hwProt;
    str.txEn     = (opcode == OP_RDSR) & (byteCnt != 2'd0);
  end
endmodule

// File: rtl/sflash_status_ctrl.sv
module sflash_status_ctrl
  import sflash_status_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int WRSR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              wpN,
  input  logic              engBusy,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              miso,
  output logic              permitArea,
  output logic              permitChip
);
  srStrobe_t str;
  logic byteDone, frameEnd, aligned, wel, wip, hwProt;
  logic [7:0] rxByte;
  logic [1:0] byteCnt;

  sflash_status_dp #(.ADDR_W(ADDR_W), .WRSR_CYCLES(WRSR_CYCLES)) dp (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .wpN(wpN),
    .engBusy(engBusy), .reqAddr(reqAddr), .str(str), .byteDone(byteDone),
    .rxByte(rxByte), .frameEnd(frameEnd), .aligned(aligned), .byteCnt(byteCnt),
    .wel(wel), .wip(wip), .hwProt(hwProt), .miso(miso),
    .permitArea(permitArea), .permitChip(permitChip)
  );

  sflash_status_ctl ctl (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .rxByte(rxByte),
    .frameEnd(frameEnd), .aligned(aligned), .byteCnt(byteCnt), .wel(wel),
    .wip(wip), .hwProt(hwProt), .str(str)
  );
endmodule

// File: tb/sflash_status_ctrl_test.sv
module sflash_status_ctrl_test;
  localparam int AW = 17;
  localparam int TCYC = 1000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, csN = 1'b1, sclk = 1'b0, mosi = 1'b0, wpN = 1'b1, engBusy = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic miso, permitArea, permitChip;
  int nChecks = 0, nFail = 0;

  sflash_status_ctrl #(.ADDR_W(AW), .WRSR_CYCLES(TCYC)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .wpN(wpN),
    .engBusy(engBusy), .reqAddr(reqAddr), .miso(miso),
    .permitArea(permitArea), .permitChip(permitChip));

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferByte(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nBits; i--) begin
      mosi = tx[i];
      waitClk(4);
      rx[i] = miso;
      sclk = 1'b1;
      waitClk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic sendFrame(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input int nBytes, input int extraBits);
    logic [7:0] junk;
    csN = 1'b0;
    waitClk(4);
    if (nBytes > 0) xferByte(b0, 8, junk);
    if (nBytes > 1) xferByte(b1, 8, junk);
    if (nBytes > 2) xferByte(b2, 8, junk);
    if (extraBits > 0) xferByte(nBytes == 0 ? b0 : 8'h00, extraBits, junk);
    waitClk(4);
    csN = 1'b1;
    waitClk(8);
  endtask

  task automatic readCheck(input string tag, input int exp);
    logic [7:0] junk, s1, s2;
    csN = 1'b0;
    waitClk(4);
    xferByte(8'h05, 8, junk);
    xferByte(8'h00, 8, s1);
    xferByte(8'h00, 8, s2);
    waitClk(4);
    csN = 1'b1;
    waitClk(8);
    check(tag, s1, exp);
    check({tag, " R2 repeat"}, s2, s1);
  endtask

  task automatic wren(); sendFrame(8'h06, 8'h00, 8'h00, 1, 0); endtask
  task automatic wrdi(); sendFrame(8'h04, 8'h00, 8'h00, 1, 0); endtask
  task automatic wrsr(input logic [7:0] d); sendFrame(8'h01, d, 8'h00, 2, 0); endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int addrs[8] = '{0, 'h7FFF, 'h8000, 'hFFFF, 'h10000, 'h17FFF, 'h18000, 'h1FFFF};
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);
    // R12 reset state
    check("R12 miso", miso, 0);
    check("R12 permitArea", permitArea, 0);
    check("R12 permitChip", permitChip, 0);
    readCheck("R12 status", 8'h00);

    // R3 latch set and clear
    wren();
    readCheck("R3 wren", 8'h02);
    wrdi();
    readCheck("R3 wrdi", 8'h00);

    // R5 write without latch ignored
    wrsr(8'h8C);
    readCheck("R5 no latch", 8'h00);

    // R4 framing errors
    sendFrame(8'h06, 8'h00, 8'h00, 0, 7);
    readCheck("R4 seven bits", 8'h00);
    sendFrame(8'h06, 8'h00, 8'h00, 2, 0);
    readCheck("R4 two bytes wren", 8'h00);
    sendFrame(8'h06, 8'h00, 8'h00, 1, 3);
    readCheck("R4 trailing bits", 8'h00);
    wren();
    sendFrame(8'h01, 8'h0C, 8'h00, 3, 0);
    readCheck("R4 three bytes wrsr", 8'h02);
    sendFrame(8'h01, 8'h00, 8'h00, 1, 0);
    readCheck("R4 one byte wrsr", 8'h02);
    wrdi();

    // R1 R5 R6 R10 R11 sweep over protect settings
    for (int bpv = 0; bpv < 4; bpv++) begin
      wren();
      wrsr(8'((bpv << 2) | 8'h73));
      readCheck("R6 busy read", (bpv << 2) | 3);
      waitClk(TCYC + 100);
      readCheck("R1 R6 after write", bpv << 2);
      wren();
      for (int k = 0; k < 8; k++) begin
        int a;
        bit prot;
        a = addrs[k];
        prot = (bpv == 3) || (bpv == 2 && a >= 'h10000) || (bpv == 1 && a >= 'h18000);
        reqAddr = AW'(a);
        waitClk(2);
        check("R10 permitArea", permitArea, prot ? 0 : 1);
        check("R11 permitChip", permitChip, bpv == 0 ? 1 : 0);
      end
      wrdi();
      waitClk(2);
      check("R10 no latch", permitArea, 0);
    end

    // R7 hardware protection
    wren();
    wrsr(8'h84);
    waitClk(TCYC + 100);
    readCheck("R5 lock bit set", 8'h84);
    wpN = 1'b0;
    wren();
    wrsr(8'h00);
    waitClk(20);
    readCheck("R7 rejected", 8'h86);
    reqAddr = AW'('h18000);
    waitClk(2);
    check("R7 R10 quarter", permitArea, 0);
    reqAddr = '0;
    waitClk(2);
    check("R10 low area", permitArea, 1);
    wpN = 1'b1;
    wrsr(8'h00);
    waitClk(TCYC + 100);
    readCheck("R7 unlocked write", 8'h00);

    // R8 R9 engine busy
    wren();
    engBusy = 1'b1;
    waitClk(4);
    check("R8 permitChip busy", permitChip, 0);
    check("R8 permitArea busy", permitArea, 0);
    readCheck("R8 busy", 8'h03);
    wrdi();
    readCheck("R9 wrdi ignored", 8'h03);
    wrsr(8'h0C);
    readCheck("R9 wrsr ignored", 8'h03);
    engBusy = 1'b0;
    waitClk(4);
    readCheck("R8 done clears latch", 8'h00);
    engBusy = 1'b1;
    wren();
    readCheck("R9 wren ignored", 8'h01);
    engBusy = 1'b0;
    waitClk(4);
    readCheck("R9 idle after", 8'h00);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule